// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo audio stream carried on a three-wire serial link and turns it into parallel samples. The link has a bit clock, a word-select line and a data line. The block runs in a system clock domain. Its `bit_en` input is a one-cycle enable that stands for a rising edge of the bit clock. On every enabled cycle the block samples the word-select line and the data line. A change in the sampled word-select level marks the end of one half of the frame and the start of the next.

There are three framings, chosen by `fmt_sel`. In the delayed-MSB framing (the one known as I2S), the MSB follows the word-select change by one bit. In the left-justified framing, the MSB arrives together with the change. In the right-justified framing, the word is 16 bits and ends just before the next change. Each completed half is delivered as a 24-bit two's-complement word with a channel tag and a one-cycle valid strobe. The data arrives MSB first. A swap input inverts the channel tagging. Conversion to analog, filtering and clock generation belong to other blocks.

Top module: `audio_serial_rx`

## Requirements
- R1: While the reset is asserted and after it is released, `smp_valid` is 0, `smp_data` is 0 and `smp_right` is 0 until the first sample is emitted.
- R2: The word-select level sampled on the first enabled cycle after reset is only a reference. The half that is running when the first word-select change is seen is discarded. The first `smp_valid` reports the half that ends at the second change.
- R3: `smp_valid` is high for exactly one clock, in the cycle after an enabled cycle whose sampled word-select level differs from the previous sampled level. Cycles with `bit_en` low sample nothing, even if the word-select line toggles.
- R4: With `fmt_sel`=1 (left-justified), the bit sampled on the enabled cycle that sees the change is bit 23 of the new word. The following bits fill bits 22, 21 and so on.
- R5: With `fmt_sel`=0 (delayed MSB), the bit sampled on the change cycle is dropped. The next enabled cycle carries bit 23.
- R6: In modes 0 and 1, a half with fewer than 24 data bits yields a word whose unfilled low bits are 0.
- R7: In modes 0 and 1, data bits after the 24th in a half do not affect the word.
- R8: With `fmt_sel`=2 (right-justified), the word is the last 16 bits sampled before the change cycle, placed in bits 23..8, with bits 7..0 at 0. Earlier bits of the half are discarded. Each half must carry at least 16 bits.
- R9: `smp_right` is 1 for a right-channel sample. In mode 0, a low word-select level is left. In modes 1 and 2, a high level is left. With `chan_swap`=1 the tag is inverted.
- R10: `smp_data` and `smp_right` keep their values between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe standing for a bit clock rising edge |
| lrck | input | 1 | Word-select line |
| sdat | input | 1 | Serial data line, MSB first |
| fmt_sel | input | 2 | Framing: 0 delayed MSB, 1 left-justified, 2 right-justified 16-bit |
| chan_swap | input | 1 | Inverts the channel tag |
| smp_data | output | 24 | Completed two's-complement sample |
| smp_right | output | 1 | Channel tag, 1 = right |
| smp_valid | output | 1 | One-cycle strobe for a new sample |

## Verification
The checker watches four things on every cycle. A strobe may only follow an enabled cycle. No strobe may come before three enabled cycles have passed since reset. Right-justified words must have their low padding at zero. The output word must not move between strobes. Only the bench's scenarios can show bit placement for each framing, the dropped bit in delayed-MSB mode, zero padding and truncation, channel polarity and the swap. The same goes for word-select toggles that fall outside enabled cycles and are therefore ignored.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  typedef enum logic [1:0] {
    FMT_DLY = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } asrx_fmt_e;
endpackage

// File: rtl/asrx_lr_track.sv
module asrx_lr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic lrck,
  output logic lr_prev,
  output logic boundary,
  output logic emit_ok
);
  logic lr_q, lr_d;
  logic ref_q, ref_d;
  logic arm_q, arm_d;

  assign boundary = bit_en && ref_q && (lrck != lr_q);
  assign emit_ok  = boundary && arm_q;
  assign lr_prev  = lr_q;

  always_comb begin
    lr_d  = lr_q;
    ref_d = ref_q;
    arm_d = arm_q;
    if (bit_en) begin
      lr_d  = lrck;
      ref_d = 1'b1;
      if (boundary) arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q  <= 1'b0;
      ref_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      lr_q  <= lr_d;
      ref_q <= ref_d;
      arm_q <= arm_d;
    end
  end
endmodule

// File: rtl/asrx_word_asm.sv
module asrx_word_asm
  import asrx_pkg::*;
#(
  parameter int W_OUT = 24,
  parameter int RJ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sdat,
  input  logic             boundary,
  input  asrx_fmt_e        fmt,
  output logic [W_OUT-1:0] word_o
);
  localparam int CW = $clog2(W_OUT + 1);

  logic [W_OUT-1:0] acc_q, acc_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RJ_W-1:0]  sh_q, sh_d;
  logic [W_OUT-1:0] rj_word;

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (bit_en) begin
      sh_d = {sh_q[RJ_W-2:0], sdat};
      if (boundary) begin
        acc_d = '0;
        cnt_d = '0;
        if (fmt != FMT_DLY) begin
          acc_d[W_OUT-1] = sdat;
          cnt_d          = CW'(1);
        end
      end else if (cnt_q < CW'(W_OUT)) begin
        for (int i = 0; i < W_OUT; i++) begin
          if (cnt_q == CW'(i)) acc_d[W_OUT-1-i] = sdat;
        end
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  generate
    if (W_OUT > RJ_W) begin : g_pad
      assign rj_word = {sh_q, {(W_OUT-RJ_W){1'b0}}};
    end else begin : g_cut
      assign rj_word = sh_q[RJ_W-1 -: W_OUT];
    end
  endgenerate

  assign word_o = (fmt == FMT_RJ) ? rj_word : acc_q;
endmodule

// File: rtl/asrx_out_reg.sv
module asrx_out_reg #(
  parameter int W_OUT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic [W_OUT-1:0] word_i,
  input  logic             right_i,
  output logic [W_OUT-1:0] data_o,
  output logic             right_o,
  output logic             valid_o
);
  logic [W_OUT-1:0] data_d;
  logic             right_d;
  logic             valid_d;

  always_comb begin
    data_d  = data_o;
    right_d = right_o;
    valid_d = 1'b0;
    if (emit) begin
      data_d  = word_i;
      right_d = right_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      right_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= data_d;
      right_o <= right_d;
      valid_o <= valid_d;
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int W_OUT = 24,
  parameter int RJ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             lrck,
  input  logic             sdat,
  input  logic [1:0]       fmt_sel,
  input  logic             chan_swap,
  output logic [W_OUT-1:0] smp_data,
  output logic             smp_right,
  output logic             smp_valid
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  asrx_fmt_e        fmt_e;
  logic             lr_prev, boundary, emit_ok;
  logic [W_OUT-1:0] word;
  logic             tag_right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign fmt_e     = asrx_fmt_e'(fmt_sel);
  assign tag_right = lr_prev ^ (fmt_e != FMT_DLY) ^ chan_swap;

  asrx_lr_track u_lr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .lrck     (lrck),
    .lr_prev  (lr_prev),
    .boundary (boundary),
    .emit_ok  (emit_ok)
  );

  asrx_word_asm #(.W_OUT(W_OUT), .RJ_W(RJ_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .sdat     (sdat),
    .boundary (boundary),
    .fmt      (fmt_e),
    .word_o   (word)
  );

  asrx_out_reg #(.W_OUT(W_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .emit    (emit_ok),
    .word_i  (word),
    .right_i (tag_right),
    .data_o  (smp_data),
    .right_o (smp_right),
    .valid_o (smp_valid)
  );
endmodule

// File: rtl/asrx_checker.sv
module asrx_checker #(
  parameter int W_OUT = 24,
  parameter int RJ_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic [1:0]       fmt_sel,
  input logic [W_OUT-1:0] smp_data,
  input logic             smp_valid
);
  logic [1:0] en_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         en_seen <= 2'd0;
    else if (bit_en && en_seen != 2'd3) en_seen <= en_seen + 2'd1;
  end

  AST_STROBE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(bit_en)); // R3

  AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> en_seen == 2'd3); // R2

  AST_RJ_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(fmt_sel) == 2'd2) |-> smp_data[W_OUT-RJ_W-1:0] == '0); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data)); // R10
endmodule

bind audio_serial_rx asrx_checker #(.W_OUT(W_OUT), .RJ_W(RJ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .fmt_sel   (fmt_sel),
  .smp_data  (smp_data),
  .smp_valid (smp_valid)
);

// File: tb/audio_serial_rx_tb.sv
`timescale 1ns/1ps
module audio_serial_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        lrck;
  logic        sdat;
  logic [1:0]  fmt_sel;
  logic        chan_swap;
  logic [23:0] smp_data;
  logic        smp_right;
  logic        smp_valid;

  int total = 0;
  int bad   = 0;
  int got_n = 0;
  logic [23:0] got_data;
  logic        got_right;

  always #2 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lrck(lrck), .sdat(sdat),
    .fmt_sel(fmt_sel), .chan_swap(chan_swap),
    .smp_data(smp_data), .smp_right(smp_right), .smp_valid(smp_valid)
  );

  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      got_n     <= got_n + 1;
      got_data  <= smp_data;
      got_right <= smp_right;
    end
  end

  // row: {fmt, swap, lrck level of half, bit count, pattern MSB-first, word, right tag}
  localparam int VN = 8;
  localparam logic [66:0] VEC [VN] = '{
    {2'd1, 1'b0, 1'b1, 6'd24, 32'hA5C3F100, 24'hA5C3F1, 1'b0}, // R4 left
    {2'd1, 1'b0, 1'b0, 6'd16, 32'h80010000, 24'h800100, 1'b1}, // R4 right, R6
    {2'd0, 1'b0, 1'b0, 6'd25, 32'h891A2B00, 24'h123456, 1'b0}, // R5 first bit dropped
    {2'd0, 1'b0, 1'b1, 6'd17, 32'h5F778000, 24'hBEEF00, 1'b1}, // R6 short word
    {2'd1, 1'b0, 1'b1, 6'd30, 32'h123456FC, 24'h123456, 1'b0}, // R7 extra bits
    {2'd2, 1'b0, 1'b1, 6'd20, 32'hFABCD000, 24'hABCD00, 1'b0}, // R8 leading bits dropped
    {2'd2, 1'b0, 1'b0, 6'd16, 32'h80010000, 24'h800100, 1'b1}, // R8 exact 16
    {2'd1, 1'b1, 1'b1, 6'd24, 32'h7FFFFF00, 24'h7FFFFF, 1'b1}  // R9 swapped tag
  };
  string vec_tag [VN] = '{"R4", "R4", "R5", "R6", "R7", "R8", "R8", "R9"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; lrck = 1'b0; sdat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    got_n = 0;
  endtask

  task automatic send_half(input logic lr, input int n, input logic [31:0] pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lrck = lr; sdat = pat[31-i]; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    rst_n = 1'b0; bit_en = 1'b0; lrck = 1'b0; sdat = 1'b0;
    fmt_sel = 2'd1; chan_swap = 1'b0;
    repeat (2) @(negedge clk);
    // R1 values during and after reset
    chk("R1", {31'd0, smp_valid}, 32'd0);
    do_reset();
    chk("R1", {8'd0, smp_data}, 32'd0);
    chk("R1", {31'd0, smp_right}, 32'd0);

    for (int v = 0; v < VN; v++) begin
      logic [1:0]  f;
      logic        sw, lr, er;
      logic [5:0]  n;
      logic [31:0] pat;
      logic [23:0] ew;
      {f, sw, lr, n, pat, ew, er} = VEC[v];
      fmt_sel = f; chan_swap = sw;
      do_reset();
      send_half(~lr, 18, 32'hFFFF_0000);
      send_half(lr, int'(n), pat);
      send_half(~lr, 1, 32'h0);
      chk({vec_tag[v], " count"}, got_n, 1);
      chk({vec_tag[v], " data"}, {8'd0, got_data}, {8'd0, ew});
      chk("R9 tag", {31'd0, got_right}, {31'd0, er});
    end

    // R2 first partial half discarded
    fmt_sel = 2'd1; chan_swap = 1'b0;
    do_reset();
    send_half(1'b1, 5, 32'hF800_0000);
    send_half(1'b0, 5, 32'hC000_0000);
    chk("R2 no early strobe", got_n, 0);
    send_half(1'b1, 1, 32'h0);
    chk("R2 first strobe", got_n, 1);
    chk("R2 data", {8'd0, got_data}, 32'h00C00000);

    // R3 word-select toggles without bit_en are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); lrck = ~lrck;
    end
    @(negedge clk); lrck = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 idle toggle", got_n, 1);
    send_half(1'b1, 3, 32'h0);
    chk("R3 no boundary", got_n, 1);

    // R10 outputs hold between strobes
    held = smp_data;
    send_half(1'b1, 6, 32'hFC00_0000);
    chk("R10 hold", {8'd0, smp_data}, {8'd0, held});
    chk("R10 strobe low", {31'd0, smp_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule